// File: doc/BRIEF.md
# Triggered Hit-Latch Pipeline Buffer

The block takes a 32-bit word of discriminated detector channels and stores it on every edge of the beam-synchronous clock in a circular delay line. When the gate input is low, the stored word is zero. Each first-level trigger takes one word from a tap that lies a host-set number of clocks in the past, so the tap makes up for the time the trigger decision takes. The block writes that word into an event store.

A captured word stays pending until a second-level accept commits it. A fast clear discards every word that is still pending. Committed words leave the block in capture order through a show-ahead read port. The event store also drives a full flag, a space-available flag and a sticky overflow flag toward the trigger logic.

Top module: `hit_latch_buffer`

## Requirements
- R1: While `gate` is high, the hit word present at a clock edge is stored in the delay line. While `gate` is low, the stored word is all zeros.
- R2: Take a `l1_trig` at edge K with look-back D. It captures the word stored at edge K−D, on all 32 bits, for D from 1 to 1023. A `dly_we` pulse loads `dly_val` and takes effect from the next edge. A loaded value of 0 acts as 1. The look-back after reset is 1.
- R3: Captured words are not readable until `l2_accept`. An accept commits every word captured before its edge. A word captured on the same edge stays pending.
- R4: `fast_clear` discards all pending words. On the same edge it overrides `l2_accept`, and a `l1_trig` on that edge is also dropped. Words that were committed earlier are kept.
- R5: `rd_data` shows the oldest committed word while `rd_avail` is high. `rd_pop` advances to the next word in capture order. A pop while `rd_avail` is low has no effect.
- R6: The event store holds 2048 words in total, counting pending words and committed words not yet read. `evt_full` is high while no free word remains.
- R7: A `l1_trig` while `evt_full` is high stores nothing and sets `overflow`. `overflow` stays set until reset.
- R8: `space_ok` is high while at least 5 free words remain, and low otherwise.
- R9: After reset, `rd_avail`, `evt_full` and `overflow` are low and `space_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-synchronous sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 32 | Discriminated channel states |
| gate | input | 1 | Sampling enable; low stores zeros |
| l1_trig | input | 1 | First-level trigger, capture one word |
| l2_accept | input | 1 | Second-level accept, commit pending words |
| fast_clear | input | 1 | Discard pending words |
| dly_we | input | 1 | Load look-back delay |
| dly_val | input | 10 | New look-back delay in clocks |
| rd_pop | input | 1 | Consume the shown committed word |
| rd_data | output | 32 | Oldest committed word |
| rd_avail | output | 1 | A committed word is readable |
| evt_full | output | 1 | No free word in the event store |
| space_ok | output | 1 | At least 5 free words remain |
| overflow | output | 1 | Sticky: a trigger was dropped while full |

## Verification
The properties assume that trigger, accept, clear and pop are one-cycle-per-edge level inputs sampled at the clock. They also assume that the look-back word has been in the delay line for at least D edges before a capture uses it. The stimulus meets the second assumption by running more than 1023 gated clocks after reset before the first trigger. It changes every control input on the falling edge only. Hit and gate follow a fixed function of the edge index, so every capture has a known expected word for any look-back.

// File: rtl/hlb_pkg.sv
package hlb_pkg;

    localparam int unsigned HLB_BANK_W     = 16;
    localparam int unsigned HLB_BANKS      = 2;
    localparam int unsigned HLB_PIPE_DEPTH = 1024;
    localparam int unsigned HLB_EVT_DEPTH  = 2048;
    localparam int unsigned HLB_SPACE_MIN  = 5;

    // What the event store write side does on an edge
    typedef enum logic [1:0] {
        WR_HOLD,
        WR_PUSH,
        WR_REWIND
    } wr_act_e;

    // Control strobes seen by the event store
    typedef struct packed {
        logic capture;
        logic commit;
        logic drop;
        logic pop;
    } ev_ctl_t;

    // A zero look-back cannot be read from the delay line; it maps to one
    function automatic int unsigned fix_delay(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/hlb_delay_bank.sv
module hlb_delay_bank #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  dout
);

    logic [W-1:0] ring [DEPTH];

    always_ff @(posedge clk) begin
        ring[wr_addr] <= din;
    end

    assign dout = ring[rd_addr];

endmodule

// File: rtl/hlb_event_store.sv
module hlb_event_store
    import hlb_pkg::*;
#(
    parameter int unsigned W         = 32,
    parameter int unsigned DEPTH     = 2048,
    parameter int unsigned SPACE_MIN = 5,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  ev_ctl_t      ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] rd_data,
    output logic         rd_avail,
    output logic         full,
    output logic         space_ok,
    output logic         overflow
);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_p, cm_p, rd_p;
    logic [PW-1:0] used, free_cnt;
    wr_act_e       act;

    assign used     = wr_p - rd_p;
    assign free_cnt = PW'(DEPTH) - used;
    assign full     = (free_cnt == '0);
    assign space_ok = (free_cnt >= PW'(SPACE_MIN));
    assign rd_avail = (cm_p != rd_p);
    assign rd_data  = store[rd_p[AW-1:0]];

    always_comb begin
        if (ctl.drop)
            act = WR_REWIND;
        else if (ctl.capture && !full)
            act = WR_PUSH;
        else
            act = WR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (act == WR_PUSH)
            store[wr_p[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p     <= '0;
            cm_p     <= '0;
            rd_p     <= '0;
            overflow <= 1'b0;
        end else begin
            case (act)
                WR_PUSH:   wr_p <= wr_p + 1'b1;
                WR_REWIND: wr_p <= cm_p;
                default:   wr_p <= wr_p;
            endcase
            if (ctl.commit && !ctl.drop)
                cm_p <= wr_p;
            if (ctl.pop && rd_avail)
                rd_p <= rd_p + 1'b1;
            if (ctl.capture && full)
                overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/hit_latch_buffer.sv
module hit_latch_buffer
    import hlb_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = HLB_BANKS,
    parameter int unsigned BANK_W     = HLB_BANK_W,
    parameter int unsigned PIPE_DEPTH = HLB_PIPE_DEPTH,
    parameter int unsigned EVT_DEPTH  = HLB_EVT_DEPTH,
    parameter int unsigned SPACE_MIN  = HLB_SPACE_MIN,
    localparam int unsigned HIT_W     = NUM_BANKS * BANK_W,
    localparam int unsigned PA_W      = $clog2(PIPE_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HIT_W-1:0] hit_in,
    input  logic             gate,
    input  logic             l1_trig,
    input  logic             l2_accept,
    input  logic             fast_clear,
    input  logic             dly_we,
    input  logic [PA_W-1:0]  dly_val,
    input  logic             rd_pop,
    output logic [HIT_W-1:0] rd_data,
    output logic             rd_avail,
    output logic             evt_full,
    output logic             space_ok,
    output logic             overflow
);

    logic [PA_W-1:0]  pipe_wa;
    logic [PA_W-1:0]  dly_q;
    logic [PA_W-1:0]  tap_a;
    logic [HIT_W-1:0] sample;
    logic [HIT_W-1:0] tap_word;
    ev_ctl_t          ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_wa <= '0;
            dly_q   <= PA_W'(1);
        end else begin
            pipe_wa <= pipe_wa + 1'b1;
            if (dly_we)
                dly_q <= PA_W'(fix_delay(int'(dly_val)));
        end
    end

    assign sample = gate ? hit_in : '0;
    assign tap_a  = pipe_wa - dly_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        hlb_delay_bank #(
            .W     (BANK_W),
            .DEPTH (PIPE_DEPTH)
        ) u_bank (
            .clk     (clk),
            .wr_addr (pipe_wa),
            .din     (sample[b*BANK_W +: BANK_W]),
            .rd_addr (tap_a),
            .dout    (tap_word[b*BANK_W +: BANK_W])
        );
    end

    assign ctl = '{capture: l1_trig, commit: l2_accept,
                   drop: fast_clear, pop: rd_pop};

    hlb_event_store #(
        .W         (HIT_W),
        .DEPTH     (EVT_DEPTH),
        .SPACE_MIN (SPACE_MIN)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .din      (tap_word),
        .rd_data  (rd_data),
        .rd_avail (rd_avail),
        .full     (evt_full),
        .space_ok (space_ok),
        .overflow (overflow)
    );

endmodule

// File: rtl/hlb_checker.sv
module hlb_checker (
    input logic clk,
    input logic rst,
    input logic l1_trig,
    input logic l2_accept,
    input logic fast_clear,
    input logic rd_pop,
    input logic rd_avail,
    input logic evt_full,
    input logic space_ok,
    input logic overflow
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R7

    AST_FULL_TRIG_OVF: assert property (@(posedge clk) disable iff (rst)
        (l1_trig && evt_full) |=> overflow); // R7

    AST_FULL_NO_SPACE: assert property (@(posedge clk) disable iff (rst)
        evt_full |-> !space_ok); // R8

    AST_SPACE_FALL_TRIG: assert property (@(posedge clk) disable iff (rst)
        $fell(space_ok) |-> $past(l1_trig)); // R8

    AST_AVAIL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_avail) |-> ($past(l2_accept) && !$past(fast_clear))); // R3

    AST_CLEAR_KEEPS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (fast_clear && !rd_pop) |=> $stable(rd_avail)); // R4

endmodule

bind hit_latch_buffer hlb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .l1_trig    (l1_trig),
    .l2_accept  (l2_accept),
    .fast_clear (fast_clear),
    .rd_pop     (rd_pop),
    .rd_avail   (rd_avail),
    .evt_full   (evt_full),
    .space_ok   (space_ok),
    .overflow   (overflow)
);

// File: tb/hit_latch_buffer_tb.sv
`timescale 1ns/1ps
module hit_latch_buffer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hit_in = '0;
    logic        gate = 1'b0;
    logic        l1_trig = 1'b0, l2_accept = 1'b0, fast_clear = 1'b0;
    logic        dly_we = 1'b0, rd_pop = 1'b0;
    logic [9:0]  dly_val = '0;
    logic [31:0] rd_data;
    logic        rd_avail, evt_full, space_ok, overflow;

    always #2.5 clk = ~clk;

    hit_latch_buffer u_dut (
        .clk(clk), .rst(rst), .hit_in(hit_in), .gate(gate),
        .l1_trig(l1_trig), .l2_accept(l2_accept), .fast_clear(fast_clear),
        .dly_we(dly_we), .dly_val(dly_val), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_avail(rd_avail), .evt_full(evt_full),
        .space_ok(space_ok), .overflow(overflow)
    );

    int tests = 0, fails = 0;
    int edge_n = 0;
    bit finished = 0;

    // Expected word pool, mirrored from the requirements
    logic [31:0] mdl [4096];
    int mw = 0, mc = 0, mr = 0;
    int cur_d = 1;

    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic logic [31:0] hf(input int k);
        return (32'(k) * 32'h9E3779B1) ^ (32'(k) << 7) ^ 32'h0000_5A5A;
    endfunction

    function automatic logic gate_of(input int k);
        return (k % 7) != 3;
    endfunction

    function automatic logic [31:0] expw(input int k);
        return gate_of(k - cur_d) ? hf(k - cur_d) : 32'h0;
    endfunction

    // Hit and gate for the coming edge, a function of its index
    always @(negedge clk) begin
        hit_in <= hf(edge_n + 1);
        gate   <= gate_of(edge_n + 1);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_model(input int k);
        if (mw - mr < 2048) begin
            mdl[mw % 4096] = expw(k);
            mw++;
        end
    endtask

    task automatic set_delay(input int d);
        @(negedge clk); dly_we = 1'b1; dly_val = 10'(d);
        @(negedge clk); dly_we = 1'b0;
        cur_d = (d == 0) ? 1 : d;
    endtask

    task automatic trig_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); l1_trig = 1'b1; push_model(edge_n + 1);
        end
        @(negedge clk); l1_trig = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk); l2_accept = 1'b1; mc = mw;
        @(negedge clk); l2_accept = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); fast_clear = 1'b1; mw = mc;
        @(negedge clk); fast_clear = 1'b0;
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        while (mr < mc) begin
            chk(req, {31'h0, rd_avail}, 32'h1);
            chk(req, rd_data, mdl[mr % 4096]);
            rd_pop = 1'b1; mr++;
            @(negedge clk);
        end
        rd_pop = 1'b0;
        chk(req, {31'h0, rd_avail}, {31'h0, (mc != mr)});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mw = 0; mc = 0; mr = 0; cur_d = 1;
    endtask

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 avail", {31'h0, rd_avail}, 32'h0);
        chk("R9 full", {31'h0, evt_full}, 32'h0);
        chk("R9 space", {31'h0, space_ok}, 32'h1);
        chk("R9 ovf", {31'h0, overflow}, 32'h0);
        repeat (1100) @(negedge clk);

        // R1: default look-back 1, seven triggers span every gate phase
        trig_n(7); accept(); drain("R1");

        // R2: look-back sweep, including 0 mapped to 1 and the maximum
        foreach (dly_list[i]) begin
            set_delay(dly_list[i]);
            trig_n(3); accept(); drain("R2");
        end

        // R3: pending is hidden; accept on a capture edge leaves it pending
        set_delay(5);
        trig_n(2);
        chk("R3 hidden", {31'h0, rd_avail}, 32'h0);
        @(negedge clk); l1_trig = 1'b1; l2_accept = 1'b1;
        mc = mw; push_model(edge_n + 1);
        @(negedge clk); l1_trig = 1'b0; l2_accept = 1'b0;
        chk("R3 visible", {31'h0, rd_avail}, 32'h1);
        drain("R3");
        chk("R3 late pending", {31'h0, rd_avail}, 32'h0);
        accept(); drain("R3");

        // R4: clear drops pending, wins over accept and over a capture
        trig_n(3); clear();
        chk("R4 clear", {31'h0, rd_avail}, 32'h0);
        trig_n(2);
        @(negedge clk); fast_clear = 1'b1; l2_accept = 1'b1; mw = mc;
        @(negedge clk); fast_clear = 1'b0; l2_accept = 1'b0;
        chk("R4 over accept", {31'h0, rd_avail}, 32'h0);
        @(negedge clk); fast_clear = 1'b1; l1_trig = 1'b1;
        @(negedge clk); fast_clear = 1'b0; l1_trig = 1'b0;
        accept();
        chk("R4 over capture", {31'h0, rd_avail}, 32'h0);
        trig_n(1); accept(); drain("R4");

        // R5: empty pop ignored, then ordered readout
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        chk("R5 empty pop", {31'h0, rd_avail}, 32'h0);
        set_delay(200);
        trig_n(4); accept(); drain("R5");

        // R6/R7/R8: fill to capacity and beyond
        trig_n(2043);
        chk("R8 five free", {31'h0, space_ok}, 32'h1);
        chk("R6 not full", {31'h0, evt_full}, 32'h0);
        trig_n(1);
        chk("R8 four free", {31'h0, space_ok}, 32'h0);
        trig_n(4);
        chk("R6 full", {31'h0, evt_full}, 32'h1);
        chk("R7 no ovf yet", {31'h0, overflow}, 32'h0);
        trig_n(1);
        chk("R7 ovf set", {31'h0, overflow}, 32'h1);
        accept(); drain("R6");
        chk("R7 sticky", {31'h0, overflow}, 32'h1);
        chk("R6 empty", {31'h0, evt_full}, 32'h0);
        chk("R8 space back", {31'h0, space_ok}, 32'h1);

        do_reset();
        chk("R9 ovf cleared", {31'h0, overflow}, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    int dly_list [8] = '{1, 2, 3, 0, 64, 513, 1000, 1023};

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule